// File: doc/BRIEF.md
# I2C Slave Own-Address Matcher

This block keeps the own-address register of an I2C slave and decides whether the first address byte of a transfer is addressed to this device. The register is eight bits wide. The seven slave-address bits sit in bits 7..1, and a direction bit sits in bit 0. A host loads the register through a simple write strobe. The serial front end supplies START and STOP detect pulses, a received byte and a byte-valid strobe.

After each START, the block evaluates only the first received byte. In 7-bit addressing mode, only the seven address bits take part in the comparison. In 10-bit addressing mode, the first byte must equal the whole register, including bit 0. The register's bit 0 is cleared by hardware on every STOP. The match flag stays valid until the next START or STOP.

Top module: `i2c_own_addr_match`

## Requirements
- R1: After reset, the register reads 0x00 on `own_addr` and `addr_match` is 0.
- R2: A cycle with `wr_en` high and `stop_det` low loads all eight bits of `wr_data` into the register. The new value appears on `own_addr` after that clock edge.
- R3: In 7-bit mode (`ten_bit_mode`=0), when the first byte after a START has bits 7..1 equal to register bits 7..1, `addr_match` is 1 in the cycle after the strobe. Bit 0 of both the byte and the register is ignored.
- R4: In 10-bit mode (`ten_bit_mode`=1), the first byte after a START sets `addr_match` in the cycle after its strobe only if all eight bits equal the register. Otherwise `addr_match` stays 0.
- R5: A STOP pulse clears register bit 0 and leaves bits 7..1 unchanged. When a host write falls in the same cycle as a STOP, bits 7..1 take the written value and bit 0 becomes 0.
- R6: `addr_match` is 0 in the cycle after any START or STOP pulse.
- R7: Only the first byte strobe after a START is evaluated. Later strobes in the same transfer leave `addr_match` unchanged. Strobes that arrive after a STOP, with no START since, are also ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host write strobe for the own-address register |
| wr_data | input | 8 | Host write data |
| ten_bit_mode | input | 1 | 1 selects 10-bit addressing, 0 selects 7-bit |
| start_det | input | 1 | One-cycle START detected pulse |
| stop_det | input | 1 | One-cycle STOP detected pulse |
| rx_byte | input | 8 | Received byte |
| rx_valid | input | 1 | One-cycle strobe marking `rx_byte` valid |
| own_addr | output | 8 | Current own-address register contents |
| addr_match | output | 1 | First-byte address match flag |

## Verification
For four register values (0xA5, 0x5A, 0x00, 0xFF), every one of the 256 byte values is presented as the first byte in both modes. The expected flag is computed arithmetically.

The odd and even register values separate the two modes. In 7-bit mode, pairs of bytes that differ only in bit 0 must both match. In 10-bit mode, only the exact byte may match.

Directed sequences then cover the remaining behaviour:
- a second byte in the same transfer, and bytes sent after a STOP without a new START, to show that these strobes are ignored;
- a STOP alone, and a STOP together with a host write, to show that bit 0 is cleared and that the hardware clear takes priority over the write.

// File: rtl/i2c_own_addr_match.sv
module i2c_own_addr_match #(
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_data,
  input  logic          ten_bit_mode,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [AW-1:0] rx_byte,
  input  logic          rx_valid,
  output logic [AW-1:0] own_addr,
  output logic          addr_match
);

  logic          armed;
  logic          hit;
  logic [AW-1:0] addr_nxt;

  assign hit = ten_bit_mode ? (rx_byte == own_addr)
                            : (rx_byte[AW-1:1] == own_addr[AW-1:1]);

  assign addr_nxt[AW-1:1] = wr_en ? wr_data[AW-1:1] : own_addr[AW-1:1];
  assign addr_nxt[0]      = stop_det ? 1'b0 : (wr_en ? wr_data[0] : own_addr[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) own_addr <= '0;
    else        own_addr <= addr_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         armed <= 1'b0;
    else if (start_det) armed <= 1'b1;
    else if (stop_det)  armed <= 1'b0;
    else if (rx_valid)  armed <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         addr_match <= 1'b0;
    else if (start_det || stop_det)     addr_match <= 1'b0;
    else if (armed && rx_valid && hit)  addr_match <= 1'b1;
  end

  AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !stop_det) |=> own_addr == $past(wr_data)); // R2

  AST_MATCH_7B: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && rx_valid && !start_det && !stop_det && !ten_bit_mode &&
     rx_byte[AW-1:1] == own_addr[AW-1:1]) |=> addr_match); // R3

  AST_NOMATCH_10B: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && rx_valid && ten_bit_mode && rx_byte != own_addr && !addr_match)
    |=> !addr_match); // R4

  AST_STOP_CLR_RW: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (own_addr[0] == 1'b0)); // R5

  AST_STOP_KEEP_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && !wr_en) |=> $stable(own_addr[AW-1:1])); // R5

  AST_FRAME_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det || stop_det) |=> !addr_match); // R6

  AST_LATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !start_det && !stop_det) |=> $stable(addr_match)); // R7

endmodule

// File: tb/i2c_own_addr_match_test.sv
module i2c_own_addr_match_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       ten_bit_mode = 1'b0;
  logic       start_det = 1'b0;
  logic       stop_det = 1'b0;
  logic [7:0] rx_byte = '0;
  logic       rx_valid = 1'b0;
  logic [7:0] own_addr;
  logic       addr_match;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  i2c_own_addr_match #(.AW(8)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ten_bit_mode(ten_bit_mode), .start_det(start_det), .stop_det(stop_det),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .own_addr(own_addr),
    .addr_match(addr_match)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic write_reg(input logic [7:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start_det = 1'b1;
    @(negedge clk); start_det = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); stop_det = 1'b1;
    @(negedge clk); stop_det = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  initial begin
    logic [7:0] regs [4];
    regs[0] = 8'hA5; regs[1] = 8'h5A; regs[2] = 8'h00; regs[3] = 8'hFF;

    repeat (3) @(negedge clk);
    chk("R1 reg", own_addr, 8'h00);
    chk("R1 match", addr_match, 0);
    rst_n = 1'b1;

    for (int r = 0; r < 4; r++) begin
      write_reg(regs[r]);
      chk("R2 load", own_addr, regs[r]);
      for (int m = 0; m < 2; m++) begin
        ten_bit_mode = m[0];
        for (int b = 0; b < 256; b++) begin
          int exp;
          pulse_start();
          chk("R6 start clr", addr_match, 0);
          send_byte(b[7:0]);
          if (m == 1) exp = (b == int'(regs[r])) ? 1 : 0;
          else        exp = ((b >> 1) == (int'(regs[r]) >> 1)) ? 1 : 0;
          chk(m == 1 ? "R4 10-bit" : "R3 7-bit", addr_match, exp);
        end
      end
    end

    ten_bit_mode = 1'b0;
    write_reg(8'h6C);
    pulse_start(); send_byte(8'h6D);
    chk("R3 match", addr_match, 1);
    send_byte(8'h12);
    chk("R7 later byte keeps", addr_match, 1);
    pulse_stop();
    chk("R6 stop clr", addr_match, 0);
    send_byte(8'h6C);
    chk("R7 no start ignored", addr_match, 0);
    pulse_start(); send_byte(8'h10);
    chk("R7 first miss", addr_match, 0);
    send_byte(8'h6C);
    chk("R7 later hit ignored", addr_match, 0);

    write_reg(8'hA5);
    pulse_stop();
    chk("R5 stop clears b0", own_addr, 8'hA4);
    @(negedge clk); wr_en = 1'b1; wr_data = 8'h3B; stop_det = 1'b1;
    @(negedge clk); wr_en = 1'b0; stop_det = 1'b0;
    chk("R5 stop wins", own_addr, 8'h3A);
    ten_bit_mode = 1'b1;
    pulse_start(); send_byte(8'h3B);
    chk("R4 cleared b0 miss", addr_match, 0);
    pulse_start(); send_byte(8'h3A);
    chk("R4 exact hit", addr_match, 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule